// File: doc/BRIEF.md
# Region-Based Access Guard

This block sits beside a processor's memory port and judges every access without changing its address. Up to eight address windows can be programmed. Each window has an inclusive lower bound and an inclusive upper bound, plus an attribute nibble. The nibble says whether the window is live, whether user-mode code may touch it, and whether it may be written or fetched from. Supervisor code may touch any live window. User code is kept out of every window that lacks its user bit, which walls off supervisor code and data.

Each request presents an address, an access kind, the privilege mode and a flag that is set while the reset handler runs. One cycle later the block returns a verdict: allowed, or trapped with a three-bit cause. The lowest four words of the address space always trap, except while the reset handler is active.

The windows are programmed through the same request channel, using a fourth access kind. Only supervisor code may program them. A user-mode attempt traps and leaves the windows unchanged.

Top module: `region_guard`

## Requirements
- R1: A verdict (`rsp_valid`, with exactly one of `rsp_allow`/`rsp_trap`) appears on the cycle after a request with `req_valid` high. A cycle with no request gives all-zero outputs on the next cycle.
- R2: After reset every window is disabled, so every memory access that does not hit the low page traps with cause 5. All outputs are zero until the first verdict.
- R3: A window matches when its enable bit (attribute bit 0) is set and lower <= address <= upper, both bounds inclusive. When windows overlap, the lowest-numbered matching window decides. An allowed verdict carries cause 0.
- R4: A read, write or fetch (`req_kind` 0, 1 or 2) whose address lies in 0x0–0xF traps with cause 1 when `req_boot` is low. When `req_boot` is high, the normal window checks apply.
- R5: A user-mode access (`req_user`=1) to a matching window whose user bit (attribute bit 1) is clear traps with cause 2.
- R6: A write (`req_kind`=1) to a matching window whose write bit (attribute bit 2) is clear traps with cause 3.
- R7: A fetch (`req_kind`=2) from a matching window whose execute bit (attribute bit 3) is clear traps with cause 4.
- R8: A read, write or fetch that matches no live window traps with cause 5.
- R9: A supervisor request with `req_kind`=3 writes `req_wdata` into the window chosen by `req_addr[4:2]`. `req_addr[9:8]` selects the field: 0 is the lower bound, 1 is the upper bound, 2 is the attribute nibble (`req_wdata[3:0]`). The request is allowed, and the new value governs the next request.
- R10: A user-mode request with `req_kind`=3 traps with cause 6 and changes no window.
- R11: Causes are checked in a fixed order: low page (1), then no match (5), then user permission (2), then write (3), then execute (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 window programming |
| req_addr | input | AW | Access address, or programming selector |
| req_wdata | input | AW | Programming data |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_boot | input | 1 | Reset handler is executing |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Access permitted |
| rsp_trap | output | 1 | Access trapped |
| rsp_cause | output | 3 | Trap cause (0 when allowed) |

## Verification
Every verdict is due exactly one clock edge after its request, and a window update is visible to the request in the following cycle. The bench drives each request on a falling edge. Its reference model computes the expected verdict at the next rising edge. The bench compares the outputs at the falling edge that follows, so every cycle, idle ones included, is compared at the one point where its result is due. The directed cases cover overlapping windows, both inclusive bounds, the low-page boundary at 0xF/0x10, and programming attempts from each mode. A random sweep follows the directed cases.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int AW   = 32,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_wdata,
  input  logic          req_user,
  input  logic          req_boot,
  output logic          rsp_valid,
  output logic          rsp_allow,
  output logic          rsp_trap,
  output logic [2:0]    rsp_cause
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  localparam logic [2:0] C_NONE = 3'd0, C_NULL = 3'd1, C_PRIV = 3'd2,
                         C_RO = 3'd3, C_NX = 3'd4, C_MISS = 3'd5, C_CFG = 3'd6;

  logic [AW-1:0] lo_q [NREG];
  logic [AW-1:0] hi_q [NREG];
  logic [3:0]    at_q [NREG];
  logic [NREG-1:0] hit;
  logic [IW-1:0]   sel;
  logic [3:0]      sel_at;
  logic [2:0]      cause;

  wire is_cfg  = (req_kind == 2'd3);
  wire low_pg  = ~|req_addr[AW-1:4] & ~req_boot;
  wire cfg_ok  = req_valid & is_cfg & ~req_user;
  wire [IW-1:0] cfg_idx = req_addr[2 +: IW];
  wire [1:0]    cfg_fld = req_addr[9:8];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_win
      assign hit[g] = at_q[g][0] & (req_addr >= lo_q[g]) & (req_addr <= hi_q[g]);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lo_q[g] <= '0;
          hi_q[g] <= '0;
          at_q[g] <= '0;
        end else if (cfg_ok && cfg_idx == IW'(g)) begin
          if (cfg_fld == 2'd0) lo_q[g] <= req_wdata;
          if (cfg_fld == 2'd1) hi_q[g] <= req_wdata;
          if (cfg_fld == 2'd2) at_q[g] <= req_wdata[3:0];
        end
      end
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (hit[i]) sel = IW'(i);
  end

  assign sel_at = at_q[sel];

  always_comb begin
    cause = C_NONE;
    if (is_cfg) begin
      if (req_user) cause = C_CFG;
    end else if (low_pg)                        cause = C_NULL;
    else if (~|hit)                             cause = C_MISS;
    else if (req_user && !sel_at[1])            cause = C_PRIV;
    else if (req_kind == 2'd1 && !sel_at[2])    cause = C_RO;
    else if (req_kind == 2'd2 && !sel_at[3])    cause = C_NX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_cause <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid & (cause == C_NONE);
      rsp_trap  <= req_valid & (cause != C_NONE);
      rsp_cause <= req_valid ? cause : 3'd0;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_allow && !rsp_trap && rsp_cause == 3'd0); // R1
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_allow, rsp_trap}) == 1); // R1
  AST_ALLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_allow |-> rsp_cause == 3'd0); // R3
  AST_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind != 2'd3 && req_addr < AW'(16) && !req_boot
      |=> rsp_trap && rsp_cause == 3'd1); // R4
  AST_USER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd3 && req_user |=> rsp_trap && rsp_cause == 3'd6); // R10
  AST_USER_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd3 && req_user |=> $stable(at_q[0]) && $stable(lo_q[0])); // R10
endmodule

// File: tb/sim_region_guard.sv
module sim_region_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_user = 1'b0, req_boot = 1'b0;
  logic rsp_valid, rsp_allow, rsp_trap;
  logic [2:0] rsp_cause;

  always #5 clk = ~clk;

  region_guard u0 (.clk, .rst_n, .req_valid, .req_kind, .req_addr, .req_wdata,
                   .req_user, .req_boot, .rsp_valid, .rsp_allow, .rsp_trap, .rsp_cause);

  int errors = 0, checks = 0;
  logic [31:0] m_lo [8], m_hi [8];
  logic [3:0]  m_at [8];
  bit e_v; int e_c;

  function automatic int model_cause(logic [31:0] a, logic [1:0] k, bit u, bit b);
    int w = -1;
    if (k == 2'd3) return u ? 6 : 0;
    if (a < 32'h10 && !b) return 1;
    for (int i = 0; i < 8; i++)
      if (w < 0 && m_at[i][0] && a >= m_lo[i] && a <= m_hi[i]) w = i;
    if (w < 0) return 5;
    if (u && !m_at[w][1]) return 2;
    if (k == 2'd1 && !m_at[w][2]) return 3;
    if (k == 2'd2 && !m_at[w][3]) return 4;
    return 0;
  endfunction

  function automatic string tag(bit v, int c);
    if (!v) return "R1";
    case (c)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; default: return "R10";
    endcase
  endfunction

  task automatic compare(string rq);
    bit ea = e_v && e_c == 0, et = e_v && e_c != 0;
    int ec = e_v ? e_c : 0;
    checks++;
    if (rsp_valid !== e_v || rsp_allow !== ea || rsp_trap !== et || rsp_cause !== 3'(ec)) begin
      errors++;
      $display("FAIL %s: got v=%0b a=%0b t=%0b c=%0d, expected v=%0b a=%0b t=%0b c=%0d",
               rq, rsp_valid, rsp_allow, rsp_trap, rsp_cause, e_v, ea, et, ec);
    end
  endtask

  task automatic step(bit v, logic [1:0] k, logic [31:0] a, logic [31:0] d, bit u, bit b);
    req_valid = v; req_kind = k; req_addr = a; req_wdata = d; req_user = u; req_boot = b;
    @(posedge clk);
    e_v = v;
    e_c = v ? model_cause(a, k, u, b) : 0;
    if (v && k == 2'd3 && !u) begin
      if (a[9:8] == 2'd0) m_lo[a[4:2]] = d;
      if (a[9:8] == 2'd1) m_hi[a[4:2]] = d;
      if (a[9:8] == 2'd2) m_at[a[4:2]] = d[3:0];
    end
    @(negedge clk);
    compare(tag(e_v, e_c));
  endtask

  task automatic prog(int idx, logic [31:0] lo, logic [31:0] hi, logic [3:0] at);
    step(1, 3, 32'(idx << 2), lo, 0, 0);
    step(1, 3, 32'((1 << 8) | (idx << 2)), hi, 0, 0);
    step(1, 3, 32'((2 << 8) | (idx << 2)), {28'd0, at}, 0, 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1: watchdog expired, got hang, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_at[i] = 0; end
    repeat (3) @(negedge clk);
    e_v = 0; e_c = 0;
    compare("R2");                              // reset outputs zero
    rst_n = 1'b1;
    step(1, 0, 32'h1000, 0, 0, 0);              // R2: no windows yet -> cause 5
    step(0, 0, 0, 0, 0, 0);                     // R1 idle
    prog(0, 32'h1000, 32'h1FFF, 4'b1101);       // R9 supervisor programming
    prog(1, 32'h1800, 32'h2FFF, 4'b0111);
    prog(2, 32'h0000, 32'h0FFF, 4'b1011);
    prog(7, 32'h8000, 32'h8FFF, 4'b0011);
    step(1, 0, 32'h1000, 0, 0, 0);              // R3 lower bound
    step(1, 0, 32'h1FFF, 0, 0, 0);              // R3 upper bound
    step(1, 0, 32'h1800, 0, 1, 0);              // R3 overlap: window 0 wins -> R5
    step(1, 1, 32'h2000, 0, 1, 0);              // R3 allowed in window 1
    step(1, 2, 32'h2000, 0, 1, 0);              // R7
    step(1, 1, 32'h8004, 0, 1, 0);              // R6
    step(1, 0, 32'h9000, 0, 0, 0);              // R8
    step(1, 0, 32'h3000, 0, 1, 0);              // R8 just past bound
    step(1, 0, 32'h0004, 0, 1, 0);              // R4
    step(1, 0, 32'h000F, 0, 0, 0);              // R4 last byte of low page
    step(1, 0, 32'h0010, 0, 1, 0);              // R4 first byte past low page
    step(1, 0, 32'h000C, 0, 0, 1);              // R4 boot exemption
    step(1, 1, 32'h0008, 0, 0, 1);              // R4 boot then R6
    step(1, 1, 32'h0004, 0, 1, 0);              // R11 low page over others
    step(1, 1, 32'h9000, 0, 1, 0);              // R11 miss over permission
    step(1, 1, 32'h1004, 0, 1, 0);              // R11 user before write check
    step(1, 3, 32'h21C, 32'hF, 1, 0);           // R10 user programming trap
    step(1, 1, 32'h8004, 0, 1, 0);              // R10 window 7 unchanged
    step(1, 3, 32'h200, 0, 0, 0);               // R9 disable window 0
    step(1, 0, 32'h1800, 0, 1, 0);              // R9 now window 1 decides
    for (int n = 0; n < 300; n++)
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 2)),
           32'($urandom_range(0, 16'h9FFF)), 0, 1'($urandom_range(0, 1)),
           $urandom_range(0, 7) == 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule